// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen architectural general registers of a 32-bit processor together with its current status word and the per-mode saved status words. Indices 0 to 7 and index 15 (the program counter) each have one physical copy. Indices 8 to 14 are steered to different physical storage depending on the 5-bit mode field of the current status word. Two combinational read ports and one synchronous write port serve the execute stage. A separate pair of controls reads and writes the current status word and the saved status word of the active mode.

The mode field also produces three decoded flags. `privileged` is set in every legal mode except user. `exception_mode` is set in the privileged modes other than system. `illegal_mode` is set when the field holds none of the seven legal encodings. All control pins are plain level signals with no handshake. Every access completes in the cycle it is presented, so the block never applies back-pressure. A status-word write that changes the mode takes effect at the next clock edge. Register and saved-status accesses in the same cycle still use the old mode.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register index reads zero in every mode, the status word reads 0x000000D3 (supervisor mode with bits 7 and 6 set), and `privileged` and `exception_mode` are 1.
- R2: Indices 0 to 7 refer to the same storage in every mode value.
- R3: Mode 0x11 (fast interrupt) has its own copies of indices 8 to 14. Modes 0x12, 0x13, 0x17 and 0x1B use the user copies of indices 8 to 12, and mode 0x10 uses the user copies of indices 8 to 14.
- R4: Modes 0x12, 0x13, 0x17 and 0x1B each have a private copy of index 13 and index 14, distinct from each other and from the user copies.
- R5: Mode 0x1F (system) uses exactly the user register set.
- R6: Index 15 is one unbanked register: a write to index 15 in any mode is read back at index 15 in every mode.
- R7: A status-word write stores bits 31:28 and 7:0 and clears every other bit. The bits are: 31 negative, 30 zero, 29 carry, 28 overflow, 7 IRQ disable, 6 FIQ disable, 5 compact-instruction state, 4:0 mode.
- R8: In a cycle where the status word is written, a register write and all reads still use the mode held before that edge. The new mapping applies from the next cycle.
- R9: Modes 0x11, 0x12, 0x13, 0x17 and 0x1B each have an independent saved status word. It is written through `spsr_wr_en`, stored with the R7 mask, and read on `spsr_rd`.
- R10: In modes 0x10 and 0x1F, and in any illegal mode, `spsr_rd` is zero and saved-status writes change nothing. In those modes `spsr_err` is 1 in any cycle with `spsr_wr_en` or `spsr_rd_en` high.
- R11: `privileged` is 1 exactly when the mode is legal and not 0x10. `exception_mode` is 1 exactly when `privileged` is 1 and the mode is not 0x1F.
- R12: A mode value outside the seven legal encodings sets `illegal_mode`, clears `privileged` and `exception_mode`, and uses the user register set.
- R13: Each read port returns the register selected by its own index. A write becomes visible on the read ports from the cycle after its clock edge; during the write cycle the ports show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | DATA_W | Register write data |
| cpsr_wr_en | input | 1 | Current status word write enable |
| cpsr_wr_data | input | 32 | Current status word write data |
| cpsr_rd | output | 32 | Current status word |
| spsr_rd_en | input | 1 | Saved status read strobe (drives the error flag only) |
| spsr_wr_en | input | 1 | Saved status write enable for the active mode |
| spsr_wr_data | input | 32 | Saved status write data |
| spsr_rd | output | 32 | Saved status word of the active mode |
| spsr_err | output | 1 | Saved status access in a mode without one |
| privileged | output | 1 | Mode is legal and not user |
| exception_mode | output | 1 | Privileged and not system |
| illegal_mode | output | 1 | Mode field holds no legal encoding |

## Verification
The bench builds the block with its default 32-bit data width. At that width the mode field has only 32 values and the index space has 16 entries. That makes it cheap to write every index under every mode value, illegal ones included, and then read all 512 mode-and-index pairs back on both ports. Expected values come from a sharing-class function worked out from the banking rules. The saved-status sweep and the flag sweep cover all 32 mode values in the same way. Directed steps cover the reset state, masking of the status word, and a mode change that coincides with a register write.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  localparam logic [31:0] PSR_MASK  = 32'hF000_00FF;
  localparam logic [31:0] PSR_RESET = 32'h0000_00D3;

  localparam int IDX_W      = 4;
  localparam int SHARED_CNT = 8;
  localparam int BANKED_CNT = 7;
  localparam int SPSR_SLOTS = 5;
  localparam int PHYS_REGS  = SHARED_CNT + 2 * BANKED_CNT + 2 * (SPSR_SLOTS - 1) + 1;
  localparam int PHYS_W     = $clog2(PHYS_REGS);
  localparam int PC_SLOT    = PHYS_REGS - 1;
  localparam int SP_BASE    = SHARED_CNT + 2 * BANKED_CNT;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  // Logical index plus active bank -> physical slot.
  function automatic logic [PHYS_W-1:0] phys_slot(logic [IDX_W-1:0] idx, bank_e bk);
    logic [PHYS_W-1:0] slot;
    slot = PHYS_W'(idx);
    if (idx == 4'd15) begin
      slot = PHYS_W'(PC_SLOT);
    end else if (idx >= 4'd8) begin
      if (bk == BK_FIQ) begin
        slot = PHYS_W'(idx) + PHYS_W'(BANKED_CNT);
      end else if (idx >= 4'd13 && bk != BK_USR) begin
        slot = PHYS_W'(SP_BASE) + PHYS_W'(2 * (int'(bk) - int'(BK_IRQ)))
             + PHYS_W'(idx - 4'd13);
      end
    end
    return slot;
  endfunction
endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
  import brf_pkg::*;
(
  input  logic [4:0] mode,
  output bank_e      bank,
  output logic       has_spsr,
  output logic       privileged,
  output logic       exception_mode,
  output logic       illegal_mode
);
  logic legal;

  always_comb begin
    bank     = BK_USR;
    has_spsr = 1'b1;
    legal    = 1'b1;
    case (mode)
      MODE_USR: has_spsr = 1'b0;
      MODE_SYS: has_spsr = 1'b0;
      MODE_FIQ: bank = BK_FIQ;
      MODE_IRQ: bank = BK_IRQ;
      MODE_SVC: bank = BK_SVC;
      MODE_ABT: bank = BK_ABT;
      MODE_UND: bank = BK_UND;
      default: begin
        has_spsr = 1'b0;
        legal    = 1'b0;
      end
    endcase
  end

  assign illegal_mode   = ~legal;
  assign privileged     = legal && (mode != MODE_USR);
  assign exception_mode = privileged && (mode != MODE_SYS);
endmodule

// File: rtl/brf_status.sv
module brf_status
  import brf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpsr_wr_en,
  input  logic [31:0] cpsr_wr_data,
  output logic [31:0] cpsr_q,
  input  bank_e       bank,
  input  logic        has_spsr,
  input  logic        spsr_wr_en,
  input  logic [31:0] spsr_wr_data,
  output logic [31:0] spsr_rd
);
  logic [31:0] slot_q [SPSR_SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpsr_q <= PSR_RESET;
    end else if (cpsr_wr_en) begin
      cpsr_q <= cpsr_wr_data & PSR_MASK;
    end
  end

  for (genvar s = 0; s < SPSR_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (spsr_wr_en && has_spsr && (int'(bank) == s + 1)) begin
        slot_q[s] <= spsr_wr_data & PSR_MASK;
      end
    end
  end

  always_comb begin
    spsr_rd = '0;
    if (has_spsr) begin
      spsr_rd = slot_q[int'(bank) - 1];
    end
  end

  AST_CPSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cpsr_wr_en |=> $stable(cpsr_q)); // R8

  AST_SPSR_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    !has_spsr |-> (spsr_rd == 32'd0)); // R10
endmodule

// File: rtl/brf_gpr_store.sv
module brf_gpr_store
  import brf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] regs [PHYS_REGS];
  logic [PHYS_W-1:0] rd_a_slot, rd_b_slot, wr_slot;

  assign rd_a_slot = phys_slot(rd_a_idx, bank);
  assign rd_b_slot = phys_slot(rd_b_idx, bank);
  assign wr_slot   = phys_slot(wr_idx, bank);

  for (genvar p = 0; p < PHYS_REGS; p++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[p] <= '0;
      end else if (wr_en && (wr_slot == PHYS_W'(p))) begin
        regs[p] <= wr_data;
      end
    end
  end

  assign rd_a_data = regs[rd_a_slot];
  assign rd_b_data = regs[rd_b_slot];

  AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15) |=> (regs[PC_SLOT] == $past(wr_data))); // R6
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpsr_wr_en,
  input  logic [31:0]       cpsr_wr_data,
  output logic [31:0]       cpsr_rd,
  input  logic              spsr_rd_en,
  input  logic              spsr_wr_en,
  input  logic [31:0]       spsr_wr_data,
  output logic [31:0]       spsr_rd,
  output logic              spsr_err,
  output logic              privileged,
  output logic              exception_mode,
  output logic              illegal_mode
);
  bank_e bank;
  logic  has_spsr;

  brf_mode_decode u_dec (
    .mode          (cpsr_rd[4:0]),
    .bank          (bank),
    .has_spsr      (has_spsr),
    .privileged    (privileged),
    .exception_mode(exception_mode),
    .illegal_mode  (illegal_mode)
  );

  brf_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpsr_wr_en  (cpsr_wr_en),
    .cpsr_wr_data(cpsr_wr_data),
    .cpsr_q      (cpsr_rd),
    .bank        (bank),
    .has_spsr    (has_spsr),
    .spsr_wr_en  (spsr_wr_en),
    .spsr_wr_data(spsr_wr_data),
    .spsr_rd     (spsr_rd)
  );

  brf_gpr_store #(.DATA_W(DATA_W)) u_gpr (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank     (bank),
    .rd_a_idx (rd_a_idx),
    .rd_a_data(rd_a_data),
    .rd_b_idx (rd_b_idx),
    .rd_b_data(rd_b_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  assign spsr_err = (spsr_wr_en || spsr_rd_en) && !has_spsr;

  AST_EXC_NEEDS_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    exception_mode |-> privileged); // R11

  AST_ILLEGAL_UNPRIV: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_mode |-> (!privileged && !exception_mode)); // R12
endmodule

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, cpsr_wr_en = 1'b0, spsr_rd_en = 1'b0, spsr_wr_en = 1'b0;
  logic [31:0] cpsr_wr_data = '0, spsr_wr_data = '0, cpsr_rd, spsr_rd;
  logic        spsr_err, privileged, exception_mode, illegal_mode;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] model [64];
  logic [31:0] smodel [32];

  always #2.5 clk = ~clk;

  banked_regfile u0 (.*);

  function automatic bit legal(int m);
    return m == 'h10 || m == 'h11 || m == 'h12 || m == 'h13 ||
           m == 'h17 || m == 'h1B || m == 'h1F;
  endfunction

  function automatic bit has_saved(int m);
    return legal(m) && m != 'h10 && m != 'h1F;
  endfunction

  function automatic int stack_k(int m);
    case (m)
      'h12: return 0;
      'h13: return 1;
      'h17: return 2;
      'h1B: return 3;
      default: return -1;
    endcase
  endfunction

  // Sharing class of (mode, index), from R2-R6 and R12.
  function automatic int cls(int m, int i);
    if (i < 8 || i == 15) return i;
    if (m == 'h11) return 16 + i;
    if (i >= 13 && stack_k(m) >= 0) return 32 + 2 * stack_k(m) + (i - 13);
    return i;
  endfunction

  function automatic string tag_of(int m, int i);
    if (i < 8) return "R2";
    if (i == 15) return "R6";
    if (!legal(m)) return "R12";
    if (m == 'h1F) return "R5";
    if (i >= 13 && stack_k(m) >= 0) return "R4";
    return "R3";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_mode(int m);
    cpsr_wr_en = 1'b1;
    cpsr_wr_data = 32'h0000_00C0 | 32'(m);
    step();
    cpsr_wr_en = 1'b0;
  endtask

  task automatic wr(int i, logic [31:0] d);
    wr_en = 1'b1; wr_idx = 4'(i); wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) model[k] = '0;
    for (int k = 0; k < 32; k++) smodel[k] = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    check("R1 cpsr", cpsr_rd, 32'h0000_00D3);
    check("R1 priv", 32'(privileged), 32'd1);
    check("R1 exc", 32'(exception_mode), 32'd1);
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); #0.1;
      check("R1 reg", rd_a_data, 32'd0);
    end

    // R7 masking
    cpsr_wr_en = 1'b1; cpsr_wr_data = 32'hFFFF_FFFF; step(); cpsr_wr_en = 1'b0;
    check("R7 mask", cpsr_rd, 32'hF000_00FF);
    cpsr_wr_en = 1'b1; cpsr_wr_data = 32'h5AA5_3C31; step(); cpsr_wr_en = 1'b0;
    check("R7 mask2", cpsr_rd, 32'h5000_0031);

    // Write every index under every mode value
    for (int m = 0; m < 32; m++) begin
      set_mode(m);
      check("R7 mode", cpsr_rd, 32'h0000_00C0 | 32'(m));
      for (int i = 0; i < 16; i++) begin
        logic [31:0] d;
        d = (32'(m) << 24) | (32'(i) << 16) | (32'hC3A5 ^ 32'(m * 16 + i));
        wr(i, d);
        model[cls(m, i)] = d;
      end
    end

    // Read back every (mode, index) on both ports; check flags
    for (int m = 0; m < 32; m++) begin
      set_mode(m);
      check("R11 priv", 32'(privileged), 32'(legal(m) && m != 'h10));
      check("R11 exc", 32'(exception_mode), 32'(legal(m) && m != 'h10 && m != 'h1F));
      check("R12 flag", 32'(illegal_mode), 32'(!legal(m)));
      for (int i = 0; i < 16; i++) begin
        rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); #0.1;
        check(tag_of(m, i), rd_a_data, model[cls(m, i)]);
        check("R13 portb", rd_b_data, model[cls(m, 15 - i)]);
      end
    end

    // R8/R13: mode change in same cycle as a write to index 8
    set_mode('h10);
    rd_a_idx = 4'd8;
    cpsr_wr_en = 1'b1; cpsr_wr_data = 32'h0000_00D1;
    wr_en = 1'b1; wr_idx = 4'd8; wr_data = 32'hDEAD_BEEF;
    #0.1;
    check("R13 old", rd_a_data, model[8]);
    step();
    cpsr_wr_en = 1'b0; wr_en = 1'b0;
    model[8] = 32'hDEAD_BEEF;
    #0.1;
    check("R8 fiq r8", rd_a_data, model[24]);
    set_mode('h10); #0.1;
    check("R8 usr r8", rd_a_data, 32'hDEAD_BEEF);

    // R9/R10: saved status under every mode value
    for (int m = 0; m < 32; m++) begin
      set_mode(m);
      spsr_wr_en = 1'b1;
      spsr_wr_data = 32'h0F0F_0F00 ^ (32'(m) * 32'h1111_1111);
      #0.1;
      check("R10 err wr", 32'(spsr_err), 32'(!has_saved(m)));
      step();
      spsr_wr_en = 1'b0;
      if (has_saved(m)) smodel[m] = (32'h0F0F_0F00 ^ (32'(m) * 32'h1111_1111)) & 32'hF000_00FF;
    end
    for (int m = 0; m < 32; m++) begin
      set_mode(m);
      spsr_rd_en = 1'b1; #0.1;
      check(has_saved(m) ? "R9 spsr" : "R10 spsr", spsr_rd, smodel[m]);
      check("R10 err rd", 32'(spsr_err), 32'(!has_saved(m)));
      spsr_rd_en = 1'b0; #0.1;
      check("R10 err idle", 32'(spsr_err), 32'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule